// File: doc/BRIEF.md
# Local Burst to Memory Command Splitter

This block sits between a local request port and a memory command scheduler. It takes one local read or write request at a time, each with a start address and a burst count of up to `MAX_BURST` words. It turns that request into a run of fixed-length memory commands of `MEM_BL` words each, with the column address stepping by `MEM_BL` from one command to the next. A burst count that does not divide evenly is rounded up to whole commands. The top `CS_W` address bits choose the chip. The rest of the address travels with each command.

A per-request auto-precharge flag is attached only to the last command of a split burst. A write carrying the multicast flag is copied to every chip, in ascending chip order. When the ECC build option is on, the multicast flag is ignored. A user refresh request always goes ahead of read and write traffic, but only at a boundary between memory commands.

The controller has three named states. `S_IDLE` waits for a request. `S_DATA` presents the current read or write command. `S_REFRESH` presents a refresh command. The transitions are as follows:
- `S_IDLE` goes to `S_REFRESH` when a refresh is pending.
- `S_IDLE` goes to `S_DATA` when a request is taken.
- `S_DATA` goes to `S_IDLE` when the final command is accepted.
- `S_DATA` goes to `S_REFRESH` when a non-final command is accepted while a refresh is pending.
- `S_DATA` stays in `S_DATA` when a non-final command is accepted and no refresh is pending.
- `S_REFRESH` goes back to `S_DATA` when the refresh is accepted in the middle of a request.
- `S_REFRESH` goes to `S_IDLE` when the refresh is accepted with no request open.

Top module: `lbs_burst_splitter`

## Requirements
- R1: `req_ready` is high only in `S_IDLE` with no refresh pending. A request is taken on `req_valid && req_ready`. No new request is taken until the last command of the previous one has been accepted. `req_ready` is low whenever `cmd_valid` is high.
- R2: A request with burst count L gives ceil(L / `MEM_BL`) back-to-back memory commands, and L = 0 counts as 1. The command kind is 0 for a read and 1 for a write.
- R3: Command s (counting from 0) of a request carries `cmd_addr` = (local address bits [`ADDR_W-CS_W-1`:0] + s·`MEM_BL`) mod 2^(`ADDR_W-CS_W`). It carries `cmd_cs` = local address bits [`ADDR_W-1`:`ADDR_W-CS_W`].
- R4: `cmd_ap` is 1 only on the final command of a chip's run, and only when the request had its auto-precharge flag set. It is 0 on every other command.
- R5: With ECC off, a write with the multicast flag is issued to chips 0, 1, … 2^`CS_W`−1 in that order. Each chip receives the full command sequence of R3, with `cmd_cs` equal to the chip number. A read ignores the multicast flag.
- R6: With `ECC_ON` = 1, the multicast flag has no effect: the write goes to the addressed chip only.
- R7: In `S_IDLE`, a pending refresh is issued before any request that is waiting, and `req_ready` stays low while the refresh is pending.
- R8: When a non-final read or write command is accepted while `rfsh_req` is high, the next command is a refresh. The interrupted request then resumes with its next command, unchanged.
- R9: A refresh command has kind 2, `cmd_cs` = 0, `cmd_addr` = 0 and `cmd_ap` = 0. `rfsh_ack` is high exactly in the cycle in which the refresh is accepted. `rfsh_req` is held high until then.
- R10: While `cmd_valid` is high and `cmd_ready` is low, all command fields stay unchanged in the next cycle.
- R11: After reset, `cmd_valid` and `rfsh_ack` are 0, and `req_ready` is 1 when no refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request taken this cycle |
| req_addr | input | ADDR_W | Local word address, chip in the top CS_W bits |
| req_len | input | $clog2(MAX_BURST+1) | Local burst count |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ap | input | 1 | Close the page after the burst |
| req_mcast | input | 1 | Copy the write to every chip |
| rfsh_req | input | 1 | User refresh request, held until acknowledged |
| rfsh_ack | output | 1 | Refresh command accepted this cycle |
| cmd_valid | output | 1 | Memory command present |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_cs | output | CS_W | Chip number of the command |
| cmd_addr | output | ADDR_W-CS_W | In-chip address of the command |
| cmd_kind | output | 2 | 0 read, 1 write, 2 refresh |
| cmd_ap | output | 1 | Auto-precharge on this command |

## Verification
The main function is swept over every burst count from 0 to the maximum, crossed with read or write, auto-precharge on or off, and multicast on or off. This separates the rounding of partial commands, the flag placement on the last command only, and the chip fan-out from the single-chip path. A start address near the top of the in-chip range shows whether the address wraps correctly. A second instance built with ECC on runs the same multicast writes, which tells the ignored flag from the honoured one. Refresh is raised both while idle alongside a waiting request and in the middle of split bursts under downstream stalls, which shows whether it is inserted only between commands and whether the interrupted burst resumes at the right command.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

    typedef enum logic [1:0] {
        KIND_RD  = 2'd0,
        KIND_WR  = 2'd1,
        KIND_REF = 2'd2
    } mem_kind_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DATA    = 2'd1,
        S_REFRESH = 2'd2
    } split_state_e;

endpackage

// File: rtl/lbs_seg_gen.sv
`timescale 1ns/1ps
// Segment counter: works out how many memory commands a request needs
// and steps the in-chip address by one memory burst per command.
module lbs_seg_gen #(
    parameter int MAW    = 14,
    parameter int LEN_W  = 5,
    parameter int MEM_BL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAW-1:0]   base_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             adv,
    input  logic             rewind,
    output logic [MAW-1:0]   seg_addr,
    output logic             seg_last
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0]  len_ext;
    logic [CW-1:0]  nseg_calc;
    logic [CW-1:0]  nseg_q;
    logic [CW-1:0]  idx_q;
    logic [MAW-1:0] base_q;
    logic [MAW-1:0] addr_q;

    assign len_ext   = {1'b0, len_in} + CW'(MEM_BL - 1);
    assign nseg_calc = len_ext / CW'(MEM_BL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nseg_q <= CW'(1);
            idx_q  <= '0;
            base_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            nseg_q <= (nseg_calc == '0) ? CW'(1) : nseg_calc;
            idx_q  <= '0;
            base_q <= base_in;
            addr_q <= base_in;
        end else if (rewind) begin
            idx_q  <= '0;
            addr_q <= base_q;
        end else if (adv) begin
            idx_q  <= idx_q + CW'(1);
            addr_q <= addr_q + MAW'(MEM_BL);
        end
    end

    assign seg_addr = addr_q;
    assign seg_last = (idx_q == nseg_q - CW'(1));
endmodule

// File: rtl/lbs_chip_seq.sv
`timescale 1ns/1ps
// Chip sequencer: holds the addressed chip, or walks every chip in
// ascending order when a request is fanned out.
module lbs_chip_seq #(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CS_W-1:0] cs_in,
    input  logic            fan_in,
    input  logic            adv,
    output logic [CS_W-1:0] chip,
    output logic            chip_last
);
    logic [CS_W-1:0] chip_q;
    logic            fan_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_q <= '0;
            fan_q  <= 1'b0;
        end else if (load) begin
            chip_q <= fan_in ? '0 : cs_in;
            fan_q  <= fan_in;
        end else if (adv) begin
            chip_q <= chip_q + CS_W'(1);
        end
    end

    assign chip      = chip_q;
    assign chip_last = !fan_q || (&chip_q);
endmodule

// File: rtl/lbs_burst_splitter.sv
`timescale 1ns/1ps
module lbs_burst_splitter #(
    parameter int ADDR_W    = 16,
    parameter int CS_W      = 2,
    parameter int MAX_BURST = 16,
    parameter int MEM_BL    = 4,
    parameter bit ECC_ON    = 1'b0,
    localparam int MAW      = ADDR_W - CS_W,
    localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_ap,
    input  logic              req_mcast,
    input  logic              rfsh_req,
    output logic              rfsh_ack,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [MAW-1:0]    cmd_addr,
    output logic [1:0]        cmd_kind,
    output logic              cmd_ap
);
    import lbs_pkg::*;

    split_state_e state_q, state_d;

    logic            write_q, ap_q, job_q;
    logic            load, seg_adv, seg_rewind, chip_adv;
    logic            fire, final_fire, fan_en;
    logic [MAW-1:0]  seg_addr;
    logic            seg_last;
    logic [CS_W-1:0] chip_cur;
    logic            chip_last;

    // A build with ECC never fans a write out.
    generate
        if (ECC_ON) begin : g_ecc
            assign fan_en = 1'b0;
        end else begin : g_noecc
            assign fan_en = req_mcast & req_write;
        end
    endgenerate

    lbs_seg_gen #(
        .MAW   (MAW),
        .LEN_W (LEN_W),
        .MEM_BL(MEM_BL)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .base_in (req_addr[MAW-1:0]),
        .len_in  (req_len),
        .adv     (seg_adv),
        .rewind  (seg_rewind),
        .seg_addr(seg_addr),
        .seg_last(seg_last)
    );

    lbs_chip_seq #(
        .CS_W(CS_W)
    ) u_chip (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cs_in    (req_addr[ADDR_W-1 -: CS_W]),
        .fan_in   (fan_en),
        .adv      (chip_adv),
        .chip     (chip_cur),
        .chip_last(chip_last)
    );

    assign fire       = cmd_valid && cmd_ready;
    assign final_fire = (state_q == S_DATA) && fire && seg_last && chip_last;

    // Next state and sequencing strobes.
    always_comb begin
        state_d    = state_q;
        load       = 1'b0;
        seg_adv    = 1'b0;
        seg_rewind = 1'b0;
        chip_adv   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (rfsh_req) begin
                    state_d = S_REFRESH;
                end else if (req_valid) begin
                    load    = 1'b1;
                    state_d = S_DATA;
                end
            end
            S_DATA: begin
                if (fire) begin
                    if (seg_last && chip_last) begin
                        state_d = S_IDLE;
                    end else begin
                        if (seg_last) begin
                            chip_adv   = 1'b1;
                            seg_rewind = 1'b1;
                        end else begin
                            seg_adv = 1'b1;
                        end
                        state_d = rfsh_req ? S_REFRESH : S_DATA;
                    end
                end
            end
            S_REFRESH: begin
                if (fire) begin
                    state_d = job_q ? S_DATA : S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register and per-request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            write_q <= 1'b0;
            ap_q    <= 1'b0;
            job_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                write_q <= req_write;
                ap_q    <= req_ap;
                job_q   <= 1'b1;
            end else if (final_fire) begin
                job_q   <= 1'b0;
            end
        end
    end

    // Outputs by state.
    always_comb begin
        req_ready = 1'b0;
        rfsh_ack  = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind  = KIND_RD;
        cmd_cs    = '0;
        cmd_addr  = '0;
        cmd_ap    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = !rfsh_req;
            end
            S_DATA: begin
                cmd_valid = 1'b1;
                cmd_kind  = write_q ? KIND_WR : KIND_RD;
                cmd_cs    = chip_cur;
                cmd_addr  = seg_addr;
                cmd_ap    = ap_q && seg_last;
            end
            S_REFRESH: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_REF;
                rfsh_ack  = cmd_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbs_split_checker.sv
`timescale 1ns/1ps
module lbs_split_checker #(
    parameter int CS_W = 2,
    parameter int MAW  = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rfsh_req,
    input logic            rfsh_ack,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [CS_W-1:0] cmd_cs,
    input logic [MAW-1:0]  cmd_addr,
    input logic [1:0]      cmd_kind,
    input logic            cmd_ap
);
    // R10: an offered command is held until taken
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_cs) &&
            $stable(cmd_addr) && $stable(cmd_kind) && $stable(cmd_ap));

    // R1: no request is taken while a command is outstanding
    a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    // R7: a pending refresh blocks new requests in idle
    a_r7_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req && !cmd_valid |-> !req_ready);

    // R9: refresh command fields
    a_r9_ref_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd2 |-> cmd_cs == '0 && cmd_addr == '0 && !cmd_ap);

    // R9: acknowledge only with an accepted refresh
    a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |-> cmd_valid && cmd_ready && cmd_kind == 2'd2);
endmodule

bind lbs_burst_splitter lbs_split_checker #(.CS_W(CS_W), .MAW(MAW)) u_chk (.*);

// File: tb/lbs_burst_splitter_test.sv
`timescale 1ns/1ps
module lbs_burst_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int CS_W   = 2;
    localparam int MAXB   = 8;
    localparam int BL     = 2;
    localparam int MAW    = ADDR_W - CS_W;
    localparam int LEN_W  = $clog2(MAXB + 1);
    localparam int NCS    = 1 << CS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic req_write = 1'b0, req_ap = 1'b0, req_mcast = 1'b0;
    logic rfsh_req = 1'b0;
    logic cmd_ready = 1'b1;

    logic a_rdy, a_ack, a_val, a_ap, b_rdy, b_ack, b_val, b_ap;
    logic [CS_W-1:0] a_cs, b_cs;
    logic [MAW-1:0]  a_addr, b_addr;
    logic [1:0]      a_kind, b_kind;

    logic o_rdy, o_ack, o_val, o_ap;
    logic [CS_W-1:0] o_cs;
    logic [MAW-1:0]  o_addr;
    logic [1:0]      o_kind;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbs_burst_splitter #(.ADDR_W(ADDR_W), .CS_W(CS_W), .MAX_BURST(MAXB),
                         .MEM_BL(BL), .ECC_ON(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid & ~sel), .req_ready(a_rdy),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_ap(req_ap), .req_mcast(req_mcast), .rfsh_req(rfsh_req & ~sel),
        .rfsh_ack(a_ack), .cmd_valid(a_val), .cmd_ready(cmd_ready & ~sel),
        .cmd_cs(a_cs), .cmd_addr(a_addr), .cmd_kind(a_kind), .cmd_ap(a_ap));

    lbs_burst_splitter #(.ADDR_W(ADDR_W), .CS_W(CS_W), .MAX_BURST(MAXB),
                         .MEM_BL(BL), .ECC_ON(1'b1)) uut_ecc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid & sel), .req_ready(b_rdy),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_ap(req_ap), .req_mcast(req_mcast), .rfsh_req(rfsh_req & sel),
        .rfsh_ack(b_ack), .cmd_valid(b_val), .cmd_ready(cmd_ready & sel),
        .cmd_cs(b_cs), .cmd_addr(b_addr), .cmd_kind(b_kind), .cmd_ap(b_ap));

    assign o_rdy  = sel ? b_rdy  : a_rdy;
    assign o_ack  = sel ? b_ack  : a_ack;
    assign o_val  = sel ? b_val  : a_val;
    assign o_ap   = sel ? b_ap   : a_ap;
    assign o_cs   = sel ? b_cs   : a_cs;
    assign o_addr = sel ? b_addr : a_addr;
    assign o_kind = sel ? b_kind : a_kind;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " valid low"}, int'(o_val), 0);
        chk({tag, " ready high"}, int'(o_rdy), 1);
        chk({tag, " ack low"}, int'(o_ack), 0);
    endtask

    task automatic chk_ref(input string tag);
        chk({tag, " R9 ref kind"}, int'(o_kind), 2);
        chk({tag, " R9 ref cs"}, int'(o_cs), 0);
        chk({tag, " R9 ref addr"}, int'(o_addr), 0);
        chk({tag, " R9 ref ap"}, int'(o_ap), 0);
        chk({tag, " R9 ack"}, int'(o_ack), 1);
        chk({tag, " R8 ref valid"}, int'(o_val), 1);
    endtask

    // Called at a negedge with the selected instance idle.
    task automatic run_burst(input logic [ADDR_W-1:0] addr, input int len,
                             input bit wr, input bit ap, input bit mc,
                             input bit ecc, input int rf_at, input int stall_mod);
        int nseg, nchips, k;
        bit fan, first;
        nseg   = (len == 0) ? 1 : (len + BL - 1) / BL;
        fan    = mc && wr && !ecc;
        nchips = fan ? NCS : 1;
        req_addr  = addr;
        req_len   = LEN_W'(len);
        req_write = wr;
        req_ap    = ap;
        req_mcast = mc;
        req_valid = 1'b1;
        cmd_ready = 1'b1;
        #1;
        chk("R1 ready before take", int'(o_rdy), 1);
        @(negedge clk);
        req_valid = 1'b0;
        first = 1'b1;
        k = 0;
        for (int c = 0; c < nchips; c++) begin
            for (int s = 0; s < nseg; s++) begin
                int exp_cs, exp_addr, exp_ap;
                bit last;
                if (!first) @(negedge clk);
                first    = 1'b0;
                exp_cs   = fan ? c : int'(addr[ADDR_W-1 -: CS_W]);
                exp_addr = (int'(addr[MAW-1:0]) + s * BL) % (1 << MAW);
                exp_ap   = (ap && s == nseg - 1) ? 1 : 0;
                last     = (c == nchips - 1) && (s == nseg - 1);
                chk("R2 cmd valid", int'(o_val), 1);
                chk("R2 cmd kind", int'(o_kind), wr ? 1 : 0);
                chk(fan ? "R5 fan cs" : (ecc ? "R6 ecc cs" : "R3 cs"), int'(o_cs), exp_cs);
                chk("R3 addr", int'(o_addr), exp_addr);
                chk("R4 ap", int'(o_ap), exp_ap);
                chk("R1 busy ready", int'(o_rdy), 0);
                chk("R9 no ack on data", int'(o_ack), 0);
                if (stall_mod != 0 && (k % stall_mod) == 1) begin
                    cmd_ready = 1'b0;
                    @(negedge clk);
                    chk("R10 held addr", int'(o_addr), exp_addr);
                    chk("R10 held cs", int'(o_cs), exp_cs);
                    chk("R10 held valid", int'(o_val), 1);
                    cmd_ready = 1'b1;
                end
                if (k == rf_at && !last) begin
                    rfsh_req = 1'b1;
                    @(negedge clk);
                    chk_ref("R8 preempt");
                    rfsh_req = 1'b0;
                end
                k++;
            end
        end
        @(negedge clk);
        chk_idle("R1 done");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [ADDR_W-1:0] a;
        int rfa;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", int'(o_val), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R11 after reset");
        sel = 1'b1;
        #1;
        chk_idle("R11 ecc after reset");
        sel = 1'b0;
        @(negedge clk);

        // Main sweep, ECC off
        for (int len = 0; len <= MAXB; len++) begin
            for (int m = 0; m < 8; m++) begin
                bit wr, ap, mc;
                wr  = m[0];
                ap  = m[1];
                mc  = m[2];
                a   = ADDR_W'((len * 37 + m * 91 + 5) % (1 << ADDR_W));
                rfa = (((len + m) % 3) == 0) ? (len % 2) : -1;
                run_burst(a, len, wr, ap, mc, 1'b0, rfa, 3);
            end
        end

        // R3: address wraps at the top of the in-chip range
        run_burst({2'd2, 8'hFF}, MAXB, 1'b1, 1'b1, 1'b0, 1'b0, -1, 0);
        run_burst({2'd3, 8'hFE}, 5, 1'b0, 1'b1, 1'b1, 1'b0, 2, 2);

        // R7: refresh and request arrive together while idle
        req_addr  = {2'd1, 8'h40};
        req_len   = LEN_W'(1);
        req_write = 1'b1;
        req_ap    = 1'b1;
        req_mcast = 1'b0;
        req_valid = 1'b1;
        rfsh_req  = 1'b1;
        cmd_ready = 1'b1;
        #1;
        chk("R7 ready low under refresh", int'(o_rdy), 0);
        @(negedge clk);
        chk_ref("R7 refresh first");
        rfsh_req = 1'b0;
        @(negedge clk);
        chk("R7 ready after refresh", int'(o_rdy), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 request follows kind", int'(o_kind), 1);
        chk("R7 request follows addr", int'(o_addr), 8'h40);
        chk("R7 request follows cs", int'(o_cs), 1);
        chk("R4 single cmd ap", int'(o_ap), 1);
        @(negedge clk);
        chk_idle("R7 done");

        // R6: ECC build ignores multicast
        sel = 1'b1;
        @(negedge clk);
        for (int len = 1; len <= MAXB; len++) begin
            a = ADDR_W'((len * 53 + 17) % (1 << ADDR_W));
            run_burst(a, len, 1'b1, len[0], 1'b1, 1'b1, (len > 2) ? 1 : -1, 3);
            run_burst(a, len, 1'b0, 1'b1, 1'b1, 1'b1, -1, 0);
        end
        sel = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule